// File: doc/BRIEF.md
# Lane-Splittable Add/Subtract Accumulator

This block is a 48-bit adder with a registered result. A mode input cuts its carry path at lane boundaries, so the same adder acts as one 48-bit lane, two 24-bit lanes or four 12-bit lanes. Each lane adds or subtracts its operand pair on its own. In accumulate operation, the lane's first operand is the registered result of the previous cycle instead of the A input, so a stream of B values is summed into the register.

A cascade carry input enters the lowest lane, and a cascade carry output leaves the top of the full-width lane. Two or more units can therefore be chained into a wider adder. Both cascade pins use borrow polarity while subtracting, which makes a subtracting chain join up with no extra logic. A synchronous clear zeroes the register on the next edge. Every output is registered, so the result appears one cycle after the inputs are sampled.

Top module: `simd_addacc`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `result_o`, `lane_cout_o` and `cas_cout_o` are all zero.
- R2: Lane layout is chosen by `mode_i`. Value 0 gives one 48-bit lane. Value 1 gives two 24-bit lanes at bits [23:0] and [47:24]. Values 2 and 3 give four 12-bit lanes at bits [11:0], [23:12], [35:24] and [47:36].
- R3: With `mode_i`=0 and `sub_i`=0, the result is A + B + `cas_cin_i`, truncated to 48 bits.
- R4: With `mode_i`=1, neither 24-bit lane receives a carry or borrow from the other.
- R5: With `mode_i`=2 or 3, none of the four 12-bit lanes receives a carry or borrow from another.
- R6: With `sub_i`=1, every lane above the lowest computes X + ~B + 1 over its own width. The lowest lane uses `cas_cin_i` as a borrow-in, so it computes X + ~B + (1 XOR `cas_cin_i`).
- R7: With `acc_i`=1, the registered result replaces A as the first operand in every lane.
- R8: With `clr_i`=1, the next edge zeroes `result_o`, `lane_cout_o` and `cas_cout_o`. This has priority over `acc_i`, `sub_i` and the operands.
- R9: `lane_cout_o[k]` is the raw carry out of the top bit of lane k, counting lanes from the least significant. Bits for lanes the mode does not have read 0. While subtracting, a 1 means the lane did not borrow.
- R10: In 48-bit mode, `cas_cout_o` is the carry out of bit 47 XOR `sub_i`, which is a borrow-out while subtracting. In split modes it is 0.
- R11: Each result and carry output reflects the inputs sampled exactly one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Lane layout: 0 = 1x48, 1 = 2x24, 2 or 3 = 4x12 |
| sub_i | input | 1 | 1 subtracts B in every lane |
| acc_i | input | 1 | 1 uses the registered result in place of A |
| clr_i | input | 1 | Synchronous clear of the result register |
| cas_cin_i | input | 1 | Cascade carry-in to the lowest lane (borrow-in while subtracting) |
| a_i | input | 48 | First operand |
| b_i | input | 48 | Second operand |
| result_o | output | 48 | Registered result |
| lane_cout_o | output | 4 | Registered per-lane carry-outs |
| cas_cout_o | output | 1 | Registered cascade carry-out (48-bit mode only) |

## Verification
Clear and accumulate can be requested in the same cycle. The bench first builds up a nonzero accumulated sum, then raises `clr_i` and `acc_i` together with a nonzero B. The scoreboard expects zeros on the next cycle, and it expects the following accumulation to start from zero rather than from the old total. Subtract and accumulate also coincide: a running difference is driven down through zero in four-lane mode. Each lane's wrap and carry-out is then judged against a model that builds the lanes by shift and mask, not by ripple.

// File: rtl/simd_addacc_pkg.sv
package simd_addacc_pkg;
  // Number of 12-bit segments; the three layouts need exactly four.
  localparam int unsigned NSEG_DEF = 4;

  typedef enum logic [1:0] {
    LAYOUT_FULL = 2'd0,
    LAYOUT_HALF = 2'd1,
    LAYOUT_QUAD = 2'd2
  } layout_e;

  // Collapse the raw mode code to a layout (code 3 behaves as quad).
  function automatic layout_e decode_layout(input logic [1:0] code);
    if (code[1])      return LAYOUT_QUAD;
    else if (code[0]) return LAYOUT_HALF;
    else              return LAYOUT_FULL;
  endfunction
endpackage

// File: rtl/addacc_seg.sv
module addacc_seg #(
  parameter int unsigned SEG_W = 12
) (
  input  logic [SEG_W-1:0] x_i,
  input  logic [SEG_W-1:0] y_i,
  input  logic             inv_i,
  input  logic             cin_i,
  output logic [SEG_W-1:0] sum_o,
  output logic             cout_o
);
  logic [SEG_W-1:0] y_eff;
  logic [SEG_W:0]   total;

  always_comb begin
    y_eff  = inv_i ? ~y_i : y_i;
    total  = {1'b0, x_i} + {1'b0, y_eff} + {{SEG_W{1'b0}}, cin_i};
    sum_o  = total[SEG_W-1:0];
    cout_o = total[SEG_W];
  end
endmodule

// File: rtl/addacc_lane_ctrl.sv
module addacc_lane_ctrl
  import simd_addacc_pkg::*;
#(
  parameter int unsigned NSEG = 4
) (
  input  logic [1:0]      mode_i,
  input  logic [NSEG-1:0] seg_cout_i,
  output logic [NSEG-1:0] seg_start_o,
  output logic [NSEG-1:0] lane_cout_o,
  output logic            top_cout_o
);
  localparam int unsigned HALF = NSEG / 2;

  layout_e lay;

  always_comb begin
    lay         = decode_layout(mode_i);
    seg_start_o = '0;
    lane_cout_o = '0;
    top_cout_o  = seg_cout_i[NSEG-1];
    for (int s = 0; s < NSEG; s++) begin
      unique case (lay)
        LAYOUT_QUAD: seg_start_o[s] = 1'b1;
        LAYOUT_HALF: seg_start_o[s] = (s % HALF) == 0;
        default:     seg_start_o[s] = (s == 0);
      endcase
    end
    unique case (lay)
      LAYOUT_QUAD: lane_cout_o = seg_cout_i;
      LAYOUT_HALF: begin
        for (int l = 0; l < 2; l++) lane_cout_o[l] = seg_cout_i[(l+1)*HALF-1];
      end
      default: lane_cout_o[0] = seg_cout_i[NSEG-1];
    endcase
  end
endmodule

// File: rtl/simd_addacc.sv
module simd_addacc
  import simd_addacc_pkg::*;
#(
  parameter int unsigned WIDTH = 48,
  parameter int unsigned NSEG  = NSEG_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic             sub_i,
  input  logic             acc_i,
  input  logic             clr_i,
  input  logic             cas_cin_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic [NSEG-1:0]  lane_cout_o,
  output logic             cas_cout_o
);
  localparam int unsigned SEG_W = WIDTH / NSEG;

  logic [WIDTH-1:0] res_q, x_op, sum_d;
  logic [NSEG-1:0]  seg_cin, seg_cout, seg_start, lane_cout_d;
  logic [NSEG-1:0]  lane_q;
  logic             top_cout, cas_d, cas_q;

  // Feedback mux: accumulate takes the register in place of A.
  assign x_op = acc_i ? res_q : a_i;

  addacc_lane_ctrl #(.NSEG(NSEG)) ctrl_i (
    .mode_i      (mode_i),
    .seg_cout_i  (seg_cout),
    .seg_start_o (seg_start),
    .lane_cout_o (lane_cout_d),
    .top_cout_o  (top_cout)
  );

  // Segmented carry chain: a lane start cuts the chain and injects sub.
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    if (s == 0) begin : g_low
      assign seg_cin[s] = cas_cin_i ^ sub_i;
    end else begin : g_up
      assign seg_cin[s] = seg_start[s] ? sub_i : seg_cout[s-1];
    end
    addacc_seg #(.SEG_W(SEG_W)) seg_i (
      .x_i    (x_op[s*SEG_W +: SEG_W]),
      .y_i    (b_i[s*SEG_W +: SEG_W]),
      .inv_i  (sub_i),
      .cin_i  (seg_cin[s]),
      .sum_o  (sum_d[s*SEG_W +: SEG_W]),
      .cout_o (seg_cout[s])
    );
  end

  assign cas_d = (decode_layout(mode_i) == LAYOUT_FULL) ? (top_cout ^ sub_i) : 1'b0;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      res_q  <= '0;
      lane_q <= '0;
      cas_q  <= 1'b0;
    end else begin
      res_q  <= sum_d;
      lane_q <= lane_cout_d;
      cas_q  <= cas_d;
    end
  end

  assign result_o    = res_q;
  assign lane_cout_o = lane_q;
  assign cas_cout_o  = cas_q;

  // ---------------- assertions ----------------
  logic live_q;
  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(clr_i)) |-> (result_o == '0 && lane_cout_o == '0 && !cas_cout_o));

  assert_split_cascade_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(mode_i) != 2'd0) |-> !cas_cout_o);

  assert_full_unused_cout_R9: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(mode_i) == 2'd0) |-> (lane_cout_o[NSEG-1:1] == '0));

  assert_half_unused_cout_R9: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(mode_i) == 2'd1) |-> (lane_cout_o[NSEG-1:2] == '0));

  assert_acc_feedback_R7: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(acc_i) && !$past(clr_i) && $past(mode_i) == 2'd0 && !$past(sub_i))
    |-> (result_o == WIDTH'($past(result_o) + $past(b_i) + WIDTH'($past(cas_cin_i)))));
endmodule

// File: tb/simd_addacc_tb_top.sv
module simd_addacc_tb_top;
  localparam int CLK_P = 10;
  localparam int W = 48;

  typedef struct {
    logic [W-1:0] res;
    logic [3:0]   lc;
    logic         cas;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_i = '0;
  logic sub_i = 0, acc_i = 0, clr_i = 0, cas_cin_i = 0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] result_o;
  logic [3:0]   lane_cout_o;
  logic         cas_cout_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [W-1:0] model_res = '0;
  exp_t sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  simd_addacc dut_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .sub_i(sub_i), .acc_i(acc_i),
    .clr_i(clr_i), .cas_cin_i(cas_cin_i), .a_i(a_i), .b_i(b_i),
    .result_o(result_o), .lane_cout_o(lane_cout_o), .cas_cout_o(cas_cout_o)
  );

  // Lane model built from shifts and masks.
  function automatic exp_t model(input logic [1:0] m, input logic sb, ac, cl, ci,
                                 input logic [W-1:0] a, b, prev, input string tag);
    exp_t e;
    int nl, lw;
    logic [63:0] msk, xv, xl, yl, s, r;
    nl = m[1] ? 4 : (m[0] ? 2 : 1);
    lw = W / nl;
    msk = (64'd1 << lw) - 64'd1;
    xv = {16'd0, (ac ? prev : a)};
    r = '0;
    e.lc = '0;
    for (int l = 0; l < nl; l++) begin
      xl = (xv >> (l*lw)) & msk;
      yl = ({16'd0, b} >> (l*lw)) & msk;
      if (sb) yl = (~yl) & msk;
      s = xl + yl + ((l == 0) ? 64'(ci ^ sb) : 64'(sb));
      r = r | ((s & msk) << (l*lw));
      e.lc[l] = s[lw];
    end
    e.res = r[W-1:0];
    e.cas = (nl == 1) ? (e.lc[0] ^ sb) : 1'b0;
    if (cl) begin
      e.res = '0; e.lc = '0; e.cas = 1'b0;
    end
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic [1:0] m, input logic sb, ac, cl, ci,
                       input logic [W-1:0] a, b, input string tag);
    exp_t e;
    @(negedge clk);
    mode_i = m; sub_i = sb; acc_i = ac; clr_i = cl; cas_cin_i = ci; a_i = a; b_i = b;
    e = model(m, sb, ac, cl, ci, a, b, model_res, tag);
    model_res = e.res;
    sb_q.push_back(e);
  endtask

  // Monitor: one expected item per edge, R11 one-cycle latency.
  always @(posedge clk) begin
    exp_t e;
    #(CLK_P/4);
    if (!rst && sb_q.size() > 0) begin
      e = sb_q.pop_front();
      n_vec++;
      if (result_o !== e.res || lane_cout_o !== e.lc || cas_cout_o !== e.cas) begin
        n_bad++;
        $display("FAIL %s (R11): got res=%h lc=%b cas=%b expected res=%h lc=%b cas=%b",
                 e.tag, result_o, lane_cout_o, cas_cout_o, e.res, e.lc, e.cas);
      end
    end
  end

  initial begin
    #(CLK_P*200000);
    n_bad++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    a_i = {W{1'b1}}; b_i = {W{1'b1}}; cas_cin_i = 1'b1;
    repeat (3) @(negedge clk);
    n_vec++;
    if (result_o !== '0 || lane_cout_o !== '0 || cas_cout_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got res=%h lc=%b cas=%b expected zeros", result_o, lane_cout_o, cas_cout_o);
    end
    rst = 1'b0;

    // R3 full-width add with cascade-in, wrap at bit 47
    drive(2'd0, 0, 0, 0, 0, 48'hFFFF_FFFF_FFFF, 48'h1, "R3 wrap R10 cas");
    drive(2'd0, 0, 0, 0, 1, 48'h0000_00FF_FFFF, 48'h0, "R3 cin ripple");
    drive(2'd0, 0, 0, 0, 1, 48'h7FFF_FFFF_FFFF, 48'h7FFF_FFFF_FFFF, "R3 R9 lc0");
    // R4 two lanes isolated
    drive(2'd1, 0, 0, 0, 0, 48'h0000_00FF_FFFF, 48'h1, "R4 low wrap");
    drive(2'd1, 0, 0, 0, 0, 48'hFFFF_FFFF_FFFF, 48'h0000_0100_0001, "R4 both wrap R9");
    drive(2'd1, 1, 0, 0, 0, 48'h0, 48'h0000_0100_0001, "R4 R6 borrow");
    // R5 four lanes isolated
    drive(2'd2, 0, 0, 0, 0, 48'hFFFF_FFFF_FFFF, 48'h0010_0100_1001, "R5 all wrap");
    drive(2'd3, 0, 0, 0, 1, 48'h0FFF_0FFF, 48'h0, "R2 mode3 R5");
    drive(2'd2, 1, 0, 0, 0, 48'h0, 48'h0010_0100_1001, "R5 R6 sub");
    // R6 full-width subtract, borrow-in and borrow-out polarity
    drive(2'd0, 1, 0, 0, 0, 48'h5, 48'h3, "R6 sub");
    drive(2'd0, 1, 0, 0, 1, 48'h5, 48'h3, "R6 borrow-in");
    drive(2'd0, 1, 0, 0, 0, 48'h3, 48'h5, "R6 R10 borrow-out");
    // R7 accumulate
    drive(2'd0, 0, 0, 1, 0, 48'h0, 48'h0, "R8 clear");
    for (int i = 0; i < 5; i++) drive(2'd0, 0, 1, 0, 0, 48'hDEAD, 48'h1234_5678_9ABC, "R7 acc48");
    // R8 clear beats accumulate in the same cycle
    drive(2'd0, 0, 1, 1, 1, 48'hFFFF, 48'hFFFF_FFFF, "R8 clr+acc");
    drive(2'd0, 0, 1, 0, 0, 48'h0, 48'h11, "R8 R7 restart");
    // R7 + R6 + R5: running difference through zero
    for (int i = 0; i < 4; i++) drive(2'd2, 1, 1, 0, 0, 48'h0, 48'h0008_0008_0008, "R7 R5 acc-sub");
    for (int i = 0; i < 3; i++) drive(2'd1, 0, 1, 0, 0, 48'h0, 48'h0080_0000_8000, "R7 R4 acc24");
    // randomized across all layouts
    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      drive(2'($urandom), r[0], r[1], (r[3:2] == 2'b11) && r[0], 1'($urandom),
            {16'($urandom), 32'($urandom)}, {16'($urandom), 32'($urandom)}, "R2 R9 random");
    end
    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule